// File: doc/BRIEF.md
# Flash Write Status Bit Generator

This block sits on the device side of a parallel NOR-style flash. It produces the status bits that the data bus returns while an embedded program or erase is running. A command decoder that is outside the block resolves addresses to sector indices and sends single-cycle command pulses. A model of the array engine, also outside the block, reports completion (`op_done`) or a pulse-count overrun (`op_fail`). The block holds the operation state, the set of sectors selected for erase and two toggle flip-flops. It tells the bus multiplexer whether a read returns status (`drive_status`) or array data.

The states are ARRAY (normal reads), PROG (program running), PROT_BUSY (a timed busy period after a command aimed only at protected sectors), ERASE_WIN (sector-erase acceptance window), ERASING, SUSPENDED (erase suspended), SUSP_PROG (program during erase suspend) and FAILED.

The transitions are:
- ARRAY→PROG or PROT_BUSY on a program command.
- ARRAY→ERASE_WIN on a sector erase.
- ARRAY→ERASING or PROT_BUSY on a chip erase.
- ERASE_WIN→ERASE_WIN on an added sector erase, which restarts the window.
- ERASE_WIN→ERASING or PROT_BUSY when the window expires.
- PROT_BUSY→ARRAY when its timer expires.
- PROG→ARRAY and ERASING→ARRAY on done.
- PROG, ERASING or SUSP_PROG→FAILED on fail.
- ERASING→SUSPENDED on suspend.
- SUSPENDED→ERASING on resume.
- SUSPENDED→SUSP_PROG on an accepted program.
- SUSP_PROG→SUSPENDED on done.
- FAILED→ARRAY on the reset command.

If a program, sector erase and chip erase arrive in the same cycle, program has priority, then sector erase. A read cycle is the span during which `ce_n` and `oe_n` are both low. The toggle bits change at the end of a read cycle, so each read sees the opposite value of the one before.

Top module: `flash_status_gen`

## Requirements
- R1: After reset `drive_status` is 0 and all four status bits read 0. In ARRAY, reads leave every status output unchanged.
- R2: `status_dq6` inverts once at the end of each read cycle, at any sector, while the state is PROG, PROT_BUSY, ERASE_WIN, ERASING, SUSP_PROG or FAILED. In ARRAY and SUSPENDED it holds.
- R3: `status_dq2` inverts at the end of a read cycle only when the state is ERASE_WIN, ERASING or SUSPENDED and the read sector is selected for erase. In SUSPENDED, a read of an unselected sector gets `drive_status`=0, so the read returns array data.
- R4: A program command to a protected sector enters PROT_BUSY for PROG_PROT_US×CLK_MHZ cycles, with `drive_status`=1, and then returns to ARRAY.
- R5: An erase whose selected sectors are all protected enters PROT_BUSY for ERASE_PROT_US×CLK_MHZ cycles and then returns to ARRAY. For a sector erase this happens when the window ends. For a chip erase it happens at once.
- R6: `op_fail` in PROG, ERASING or SUSP_PROG enters FAILED. There `status_dq5`=1 and `drive_status`=1. Only `cmd_reset` leaves FAILED; every other command is ignored.
- R7: `status_dq3` is 0 in ERASE_WIN and 1 in ERASING, SUSPENDED and SUSP_PROG. ERASE_WIN lasts WIN_US×CLK_MHZ cycles after the latest sector erase command, and each added sector erase restarts it. A chip erase goes to ERASING with no window.
- R8: Suspend in ERASING goes to SUSPENDED and resume goes back. In SUSPENDED, a program to a sector that is neither protected nor selected enters SUSP_PROG, and any other program is ignored. `op_done` in SUSP_PROG returns to SUSPENDED.
- R9: `op_done` in PROG or ERASING returns to ARRAY and empties the erase selection. A command that a state does not list has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| rd_sector | input | $clog2(NSEC) | Sector index of the current read address |
| cmd_sector | input | $clog2(NSEC) | Sector index carried with a program or sector erase command |
| cmd_program | input | 1 | Program command pulse |
| cmd_sector_erase | input | 1 | Sector erase command pulse |
| cmd_chip_erase | input | 1 | Chip erase command pulse |
| cmd_suspend | input | 1 | Erase suspend command pulse |
| cmd_resume | input | 1 | Erase resume command pulse |
| cmd_reset | input | 1 | Reset command pulse (leaves FAILED) |
| op_done | input | 1 | The running program or erase has completed |
| op_fail | input | 1 | The running operation has exceeded its pulse-count limit |
| sector_prot | input | NSEC | Per-sector protection flags |
| drive_status | output | 1 | 1: reads return status bits; 0: reads return array data |
| status_dq6 | output | 1 | Toggle bit, any address |
| status_dq5 | output | 1 | Timing-limit failure |
| status_dq3 | output | 1 | Erase begun (0 during the acceptance window) |
| status_dq2 | output | 1 | Toggle bit, erase-selected sectors only |

## Verification
The bench builds the block with CLK_MHZ=4 and keeps the default time settings. This gives an acceptance window of 200 cycles, a protected-program busy period of 8 cycles and a protected-erase busy period of 400 cycles. At these lengths, restarting the window, expiring it into PROT_BUSY or into ERASING, and both protected fallbacks each fit within a few hundred cycles. The 8-cycle program busy period is long enough to see `drive_status` high before the return to ARRAY. With NSEC=8 and sectors 6 and 7 protected, random reads land on selected, unselected and protected sectors in every state.

// File: rtl/fsg_pkg.sv
package fsg_pkg;

    typedef enum logic [2:0] {
        ST_ARRAY,
        ST_PROG,
        ST_PROT_BUSY,
        ST_ERASE_WIN,
        ST_ERASING,
        ST_SUSPENDED,
        ST_SUSP_PROG,
        ST_FAILED
    } fsg_state_t;

endpackage

// File: rtl/fsg_read_edge.sv
// Detects the end of a read cycle: the combined strobe (both enables low)
// was active in the previous cycle and is inactive now.
module fsg_read_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic oe_n,
    output logic rd_done
);
    logic rd_active;
    logic rd_q;

    assign rd_active = !ce_n && !oe_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= 1'b0;
        else        rd_q <= rd_active;
    end

    assign rd_done = rd_q && !rd_active;

endmodule

// File: rtl/fsg_timer.sv
// Down-counter for the acceptance window and the protected busy periods.
module fsg_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expire
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cnt <= '0;
        else if (load)          cnt <= load_val;
        else if (cnt != '0)     cnt <= cnt - 1'b1;
    end

    assign expire = (cnt == CNT_W'(1));

    // R7: once it reaches zero without a reload, the count stays at zero
    assert_timer_rests_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0 && !load) |=> (cnt == '0));

endmodule

// File: rtl/fsg_sector_track.sv
// Set of sectors selected for erase.
module fsg_sector_track #(
    parameter int NSEC  = 8,
    parameter int SEC_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             add_en,
    input  logic [SEC_W-1:0] add_idx,
    input  logic             set_all,
    input  logic             clear,
    input  logic [NSEC-1:0]  prot,
    input  logic [SEC_W-1:0] rd_idx,
    input  logic [SEC_W-1:0] cmd_idx,
    output logic             rd_hit,
    output logic             cmd_hit,
    output logic             none_erasable
);
    logic [NSEC-1:0] sel;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       sel <= '0;
        else if (clear)   sel <= '0;
        else if (set_all) sel <= '1;
        else if (add_en)  sel[add_idx] <= 1'b1;
    end

    assign rd_hit        = sel[rd_idx];
    assign cmd_hit       = sel[cmd_idx];
    assign none_erasable = ((sel & ~prot) == '0);

    // R9: leaving for ARRAY empties the selection
    assert_clear_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (sel == '0));

endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
    import fsg_pkg::*;
#(
    parameter int NSEC          = 8,
    parameter int CLK_MHZ       = 125,
    parameter int WIN_US        = 50,
    parameter int PROG_PROT_US  = 2,
    parameter int ERASE_PROT_US = 100
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ce_n,
    input  logic                    oe_n,
    input  logic [$clog2(NSEC)-1:0] rd_sector,
    input  logic [$clog2(NSEC)-1:0] cmd_sector,
    input  logic                    cmd_program,
    input  logic                    cmd_sector_erase,
    input  logic                    cmd_chip_erase,
    input  logic                    cmd_suspend,
    input  logic                    cmd_resume,
    input  logic                    cmd_reset,
    input  logic                    op_done,
    input  logic                    op_fail,
    input  logic [NSEC-1:0]         sector_prot,
    output logic                    drive_status,
    output logic                    status_dq6,
    output logic                    status_dq5,
    output logic                    status_dq3,
    output logic                    status_dq2
);
    localparam int SEC_W       = $clog2(NSEC);
    localparam int WIN_CYC     = CLK_MHZ * WIN_US;
    localparam int PPROT_CYC   = CLK_MHZ * PROG_PROT_US;
    localparam int EPROT_CYC   = CLK_MHZ * ERASE_PROT_US;
    localparam int MAX_A       = (WIN_CYC > PPROT_CYC) ? WIN_CYC : PPROT_CYC;
    localparam int MAX_CYC     = (MAX_A > EPROT_CYC) ? MAX_A : EPROT_CYC;
    localparam int CNT_W       = $clog2(MAX_CYC + 1);

    fsg_state_t       state, state_nx;
    logic             rd_done;
    logic             tmr_load, tmr_expire;
    logic [CNT_W-1:0] tmr_val;
    logic             trk_add, trk_all, trk_clear;
    logic             rd_hit, cmd_hit, none_erasable;
    logic             t6_live, t2_live;
    logic             tog6, tog2;

    fsg_read_edge u_read_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .ce_n    (ce_n),
        .oe_n    (oe_n),
        .rd_done (rd_done)
    );

    fsg_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expire   (tmr_expire)
    );

    fsg_sector_track #(.NSEC(NSEC), .SEC_W(SEC_W)) u_track (
        .clk           (clk),
        .rst_n         (rst_n),
        .add_en        (trk_add),
        .add_idx       (cmd_sector),
        .set_all       (trk_all),
        .clear         (trk_clear),
        .prot          (sector_prot),
        .rd_idx        (rd_sector),
        .cmd_idx       (cmd_sector),
        .rd_hit        (rd_hit),
        .cmd_hit       (cmd_hit),
        .none_erasable (none_erasable)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_ARRAY;
        else        state <= state_nx;
    end

    // next state, timer loads and selection updates
    always_comb begin
        state_nx = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        trk_add  = 1'b0;
        trk_all  = 1'b0;
        unique case (state)
            ST_ARRAY: begin
                if (cmd_program) begin
                    if (sector_prot[cmd_sector]) begin
                        state_nx = ST_PROT_BUSY;
                        tmr_load = 1'b1;
                        tmr_val  = CNT_W'(PPROT_CYC);
                    end else begin
                        state_nx = ST_PROG;
                    end
                end else if (cmd_sector_erase) begin
                    state_nx = ST_ERASE_WIN;
                    trk_add  = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(WIN_CYC);
                end else if (cmd_chip_erase) begin
                    trk_all = 1'b1;
                    if (&sector_prot) begin
                        state_nx = ST_PROT_BUSY;
                        tmr_load = 1'b1;
                        tmr_val  = CNT_W'(EPROT_CYC);
                    end else begin
                        state_nx = ST_ERASING;
                    end
                end
            end
            ST_PROG: begin
                if (op_fail)      state_nx = ST_FAILED;
                else if (op_done) state_nx = ST_ARRAY;
            end
            ST_PROT_BUSY: begin
                if (tmr_expire) state_nx = ST_ARRAY;
            end
            ST_ERASE_WIN: begin
                if (cmd_sector_erase) begin
                    trk_add  = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(WIN_CYC);
                end else if (tmr_expire) begin
                    if (none_erasable) begin
                        state_nx = ST_PROT_BUSY;
                        tmr_load = 1'b1;
                        tmr_val  = CNT_W'(EPROT_CYC);
                    end else begin
                        state_nx = ST_ERASING;
                    end
                end
            end
            ST_ERASING: begin
                if (op_fail)          state_nx = ST_FAILED;
                else if (op_done)     state_nx = ST_ARRAY;
                else if (cmd_suspend) state_nx = ST_SUSPENDED;
            end
            ST_SUSPENDED: begin
                if (cmd_resume)
                    state_nx = ST_ERASING;
                else if (cmd_program && !sector_prot[cmd_sector] && !cmd_hit)
                    state_nx = ST_SUSP_PROG;
            end
            ST_SUSP_PROG: begin
                if (op_fail)      state_nx = ST_FAILED;
                else if (op_done) state_nx = ST_SUSPENDED;
            end
            ST_FAILED: begin
                if (cmd_reset) state_nx = ST_ARRAY;
            end
            default: state_nx = ST_ARRAY;
        endcase
    end

    assign trk_clear = (state != ST_ARRAY) && (state_nx == ST_ARRAY);

    // outputs decoded from the state
    always_comb begin
        drive_status = 1'b1;
        status_dq5   = 1'b0;
        status_dq3   = 1'b0;
        t6_live      = 1'b0;
        t2_live      = 1'b0;
        unique case (state)
            ST_ARRAY:     drive_status = 1'b0;
            ST_PROG:      t6_live = 1'b1;
            ST_PROT_BUSY: t6_live = 1'b1;
            ST_ERASE_WIN: begin
                t6_live = 1'b1;
                t2_live = 1'b1;
            end
            ST_ERASING: begin
                t6_live    = 1'b1;
                t2_live    = 1'b1;
                status_dq3 = 1'b1;
            end
            ST_SUSPENDED: begin
                t2_live      = 1'b1;
                status_dq3   = 1'b1;
                drive_status = rd_hit;
            end
            ST_SUSP_PROG: begin
                t6_live    = 1'b1;
                status_dq3 = 1'b1;
            end
            ST_FAILED: begin
                t6_live    = 1'b1;
                status_dq5 = 1'b1;
            end
            default: drive_status = 1'b0;
        endcase
    end

    // toggle flip-flops advance at the end of each read cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tog6 <= 1'b0;
            tog2 <= 1'b0;
        end else begin
            if (rd_done && t6_live)           tog6 <= ~tog6;
            if (rd_done && t2_live && rd_hit) tog2 <= ~tog2;
        end
    end

    assign status_dq6 = tog6;
    assign status_dq2 = tog2;

    assert_dq6_flip_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_done && t6_live) |=> (status_dq6 != $past(status_dq6)));

    assert_dq6_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_done && t6_live) |=> $stable(status_dq6));

    assert_dq2_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_done && t2_live && rd_hit) |=> $stable(status_dq2));

    assert_prot_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PROT_BUSY && tmr_expire) |=> (state == ST_ARRAY));

    assert_fail_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (status_dq5 && !cmd_reset) |=> status_dq5);

    assert_window_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ERASE_WIN && tmr_expire && !cmd_sector_erase)
            |=> (status_dq3 || state == ST_PROT_BUSY));

endmodule

// File: tb/flash_status_gen_bench.sv
module flash_status_gen_bench;

    localparam int NSEC = 8;
    localparam int MHZ  = 4;
    localparam int WIN  = MHZ * 50;
    localparam int PP   = MHZ * 2;
    localparam int EP   = MHZ * 100;

    localparam int M_ARRAY = 0, M_PROG = 1, M_PROT = 2, M_WIN = 3,
                   M_ERASING = 4, M_SUSP = 5, M_SPROG = 6, M_FAIL = 7;
    localparam int K_PROG = 0, K_SERASE = 1, K_CHIP = 2, K_SUSP = 3,
                   K_RESUME = 4, K_RESET = 5, K_DONE = 6, K_FAIL = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1, oe_n = 1'b1;
    logic [2:0] rd_sector = '0, cmd_sector = '0;
    logic cmd_program = 0, cmd_sector_erase = 0, cmd_chip_erase = 0;
    logic cmd_suspend = 0, cmd_resume = 0, cmd_reset = 0, op_done = 0, op_fail = 0;
    logic [NSEC-1:0] sector_prot = 8'hC0;
    logic drive_status, status_dq6, status_dq5, status_dq3, status_dq2;

    int n_chk = 0, n_bad = 0;
    int mst = M_ARRAY;
    int mprot_len = 0;
    logic [NSEC-1:0] msel = '0;
    logic m6 = 1'b0, m2 = 1'b0;

    always #4 clk = ~clk;

    flash_status_gen #(.NSEC(NSEC), .CLK_MHZ(MHZ)) u_flash_status_gen (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n),
        .rd_sector(rd_sector), .cmd_sector(cmd_sector),
        .cmd_program(cmd_program), .cmd_sector_erase(cmd_sector_erase),
        .cmd_chip_erase(cmd_chip_erase), .cmd_suspend(cmd_suspend),
        .cmd_resume(cmd_resume), .cmd_reset(cmd_reset),
        .op_done(op_done), .op_fail(op_fail), .sector_prot(sector_prot),
        .drive_status(drive_status), .status_dq6(status_dq6),
        .status_dq5(status_dq5), .status_dq3(status_dq3), .status_dq2(status_dq2)
    );

    function automatic logic exp_drive(int s, logic [2:0] sec);
        return (s != M_ARRAY) && !(s == M_SUSP && !msel[sec]);
    endfunction
    function automatic logic exp_dq3(int s);
        return (s == M_ERASING) || (s == M_SUSP) || (s == M_SPROG);
    endfunction
    function automatic logic live6(int s);
        return (s == M_PROG) || (s == M_PROT) || (s == M_WIN) ||
               (s == M_ERASING) || (s == M_SPROG) || (s == M_FAIL);
    endfunction
    function automatic logic live2(int s);
        return (s == M_WIN) || (s == M_ERASING) || (s == M_SUSP);
    endfunction

    task automatic chk(string req, string what, logic got, logic exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0b expected %0b", req, what, got, exp);
        end
    endtask

    task automatic do_read(logic [2:0] sec, string req);
        @(negedge clk);
        rd_sector = sec; ce_n = 0; oe_n = 0;
        @(negedge clk);
        chk(req, "drive_status", drive_status, exp_drive(mst, sec));
        chk(req, "dq6", status_dq6, m6);
        chk(req, "dq5", status_dq5, mst == M_FAIL);
        chk(req, "dq3", status_dq3, exp_dq3(mst));
        chk(req, "dq2", status_dq2, m2);
        ce_n = 1; oe_n = 1;
        @(negedge clk);
        if (live6(mst)) m6 = ~m6;
        if (live2(mst) && msel[sec]) m2 = ~m2;
    endtask

    task automatic issue(int k, logic [2:0] sec);
        @(negedge clk);
        cmd_sector = sec;
        case (k)
            K_PROG:   cmd_program = 1;
            K_SERASE: cmd_sector_erase = 1;
            K_CHIP:   cmd_chip_erase = 1;
            K_SUSP:   cmd_suspend = 1;
            K_RESUME: cmd_resume = 1;
            K_RESET:  cmd_reset = 1;
            K_DONE:   op_done = 1;
            default:  op_fail = 1;
        endcase
        @(negedge clk);
        {cmd_program, cmd_sector_erase, cmd_chip_erase, cmd_suspend,
         cmd_resume, cmd_reset, op_done, op_fail} = '0;
        case (mst)
            M_ARRAY: begin
                if (k == K_PROG) begin
                    if (sector_prot[sec]) begin mst = M_PROT; mprot_len = PP; end
                    else mst = M_PROG;
                end else if (k == K_SERASE) begin
                    msel[sec] = 1; mst = M_WIN;
                end else if (k == K_CHIP) begin
                    msel = '1;
                    if (&sector_prot) begin mst = M_PROT; mprot_len = EP; end
                    else mst = M_ERASING;
                end
            end
            M_PROG:    if (k == K_FAIL) mst = M_FAIL; else if (k == K_DONE) mst = M_ARRAY;
            M_WIN:     if (k == K_SERASE) msel[sec] = 1;
            M_ERASING: if (k == K_FAIL) mst = M_FAIL; else if (k == K_DONE) mst = M_ARRAY;
                       else if (k == K_SUSP) mst = M_SUSP;
            M_SUSP:    if (k == K_RESUME) mst = M_ERASING;
                       else if (k == K_PROG && !sector_prot[sec] && !msel[sec]) mst = M_SPROG;
            M_SPROG:   if (k == K_FAIL) mst = M_FAIL; else if (k == K_DONE) mst = M_SUSP;
            M_FAIL:    if (k == K_RESET) mst = M_ARRAY;
            default: ;
        endcase
        if (mst == M_ARRAY) msel = '0;
    endtask

    task automatic settle();
        while (mst == M_WIN || mst == M_PROT) begin
            if (mst == M_WIN) begin
                repeat (WIN + 2) @(negedge clk);
                if ((msel & ~sector_prot) == '0) begin mst = M_PROT; mprot_len = EP; end
                else mst = M_ERASING;
            end else begin
                repeat (mprot_len + 2) @(negedge clk);
                mst = M_ARRAY; msel = '0;
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL R1 watchdog: got 0 expected 1 (run did not end)");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2417));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "drive_status", drive_status, 0);
        chk("R1", "dq6", status_dq6, 0);
        chk("R1", "dq5", status_dq5, 0);
        chk("R1", "dq3", status_dq3, 0);
        chk("R1", "dq2", status_dq2, 0);
        do_read(0, "R1"); do_read(3, "R1");
        // R9 commands not listed for ARRAY are ignored
        issue(K_SUSP, 0); issue(K_DONE, 0); issue(K_RESET, 0); issue(K_RESUME, 0);
        do_read(1, "R9");
        // R2 program toggles dq6 at any sector
        issue(K_PROG, 1);
        do_read(1, "R2"); do_read(5, "R2"); do_read(7, "R2");
        issue(K_DONE, 1);
        do_read(1, "R9"); do_read(2, "R9");
        // R4 protected program
        issue(K_PROG, 6);
        chk("R4", "drive_status busy", drive_status, 1);
        settle();
        chk("R4", "drive_status after busy", drive_status, 0);
        do_read(6, "R4");
        // R7 window, restart, then erase begun
        issue(K_SERASE, 2);
        do_read(2, "R7"); do_read(2, "R7");
        repeat (WIN - 12) @(negedge clk);
        issue(K_SERASE, 3);
        repeat (WIN - 10) @(negedge clk);
        do_read(3, "R7");
        settle();
        do_read(3, "R7"); do_read(5, "R3"); do_read(2, "R3");
        // R8 suspend and suspend-program
        issue(K_SUSP, 0);
        do_read(5, "R3"); do_read(2, "R8"); do_read(3, "R8");
        issue(K_PROG, 2); do_read(2, "R8");
        issue(K_PROG, 6); do_read(3, "R8");
        issue(K_PROG, 4); do_read(4, "R8"); do_read(0, "R8");
        issue(K_DONE, 4); do_read(2, "R8");
        issue(K_RESUME, 0); do_read(3, "R8");
        // R6 failure is sticky until reset command
        issue(K_FAIL, 0);
        do_read(0, "R6");
        issue(K_SUSP, 0); issue(K_DONE, 0); issue(K_RESUME, 0);
        do_read(2, "R6");
        issue(K_RESET, 0);
        do_read(2, "R6");
        // R5 erase of protected sectors only
        issue(K_SERASE, 6); issue(K_SERASE, 7);
        repeat (WIN + 2) @(negedge clk);
        mst = M_PROT; mprot_len = EP;
        do_read(6, "R5"); do_read(0, "R5");
        settle();
        do_read(6, "R5");
        sector_prot = 8'hFF;
        issue(K_CHIP, 0);
        do_read(1, "R5");
        settle();
        do_read(1, "R5");
        sector_prot = 8'hC0;
        // R7 chip erase skips the window
        issue(K_CHIP, 0);
        do_read(4, "R7");
        issue(K_DONE, 0);
        do_read(4, "R9");
        // random mix
        for (int i = 0; i < 400; i++) begin
            int r;
            r = int'($urandom % 16);
            if (r < 8) begin
                do_read(3'($urandom % 8), "R2");
            end else begin
                int k;
                k = int'($urandom % 8);
                if (k == K_CHIP && ($urandom % 4) != 0) k = K_DONE;
                issue(k, 3'($urandom % 8));
                settle();
            end
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule